// File: doc/BRIEF.md
# Real-Mode Segment Address Translator

This block forms linear addresses the way a legacy segmented processor does in real mode. It holds four 16-bit segment registers: code (index 0), data (index 1), stack (index 2) and extra (index 3). Software loads them through a simple write port. Each request names a default segment and may also carry an override. The block multiplies the chosen segment value by 16 and adds the zero-extended 16-bit offset. The result is a 21-bit linear address.

A gate input sets what happens to the carry out of bit 19. With the gate closed, the address wraps inside 1 MB, which reproduces the historic wrap-around. With the gate open, bit 20 is kept, so addresses up to 64 KB minus 16 bytes past the 1 MB boundary can be reached.

The block makes no bounds or privilege check. Any pair is translated, and segments may overlap, so many pairs can give the same address.

Requests and responses use valid/ready handshakes, with one register stage between them. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle. A response is consumed on an edge where `rsp_valid` and `rsp_ready` are both high. While a response waits, it holds its value. A new request is accepted only when the output stage is empty or is being drained on that same edge, so back-pressure passes straight to the requester with no extra buffering.

Top module: `seg_xlat_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and all four segment registers read 0000h, so a request with offset 0000h returns address 000000h whichever index it uses.
- R2: With `a20_enable`=1, the response address is segment×16 + offset over the full 21 bits. Examples: 06EFh:1234h gives 008124h, and FFFFh:0010h gives 100000h.
- R3: With `a20_enable`=0, bit 20 of the response is 0 and the lower 20 bits are the sum taken modulo 2^20. Examples: FFFFh:0010h gives 00000h, and FFF0h:0100h gives 00000h.
- R4: A write with `seg_wr_en`=1 loads `seg_wr_data` into the register chosen by `seg_wr_sel`, using the encoding 0=code, 1=data, 2=stack, 3=extra. Later requests use the new value. Different pairs can alias: 0812h:0004h and 0000h:8124h both give 08124h.
- R5: When `req_ovr_valid`=1, the register chosen by `req_ovr_sel` is used. Otherwise the register chosen by `req_seg_sel` is used.
- R6: A request accepted on one edge, while the output stage is empty, raises `rsp_valid` on that edge, so the response is valid in the following cycle.
- R7: A register write in the same cycle as an accepted request that selects the same register is seen by that request.
- R8: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` stays high and `rsp_addr` does not change on the next cycle.
- R9: The highest address the block can produce is 10FFEFh (FFFFh:FFFFh with the gate open). With the gate closed, that same pair gives 0FFEFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | Value to write |
| a20_enable | input | 1 | 1 keeps the carry into bit 20; 0 wraps at 1 MB |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_seg_sel | input | 2 | Default segment index |
| req_ovr_valid | input | 1 | Override index is valid |
| req_ovr_sel | input | 2 | Override segment index |
| req_offset | input | 16 | Offset within the segment |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 21 | Linear address |

## Verification
Several behaviours are checked by assertions on every cycle:
- a response held under back-pressure stays stable;
- an accepted request always produces a response on the next cycle;
- `req_ready` is high whenever the output stage is empty;
- a request accepted with the gate closed never sets bit 20;
- no response ever exceeds 10FFEFh.

The exact arithmetic can only be shown by the bench's scenarios, which compare responses with an independent model. This covers aliasing, the wrap corners at FFFFh and FFF0h, override precedence, the same-cycle write bypass and the reset contents, under random back-pressure.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int unsigned SEG_W   = 16;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned PARA_SH = 4;
  localparam int unsigned NUM_SEG = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_SEG);
  localparam int unsigned LIN_W   = SEG_W + PARA_SH + 1;

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int unsigned NUM   = seg_xlat_pkg::NUM_SEG,
  parameter int unsigned WIDTH = seg_xlat_pkg::SEG_W,
  localparam int unsigned SW   = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [SW-1:0]    rd_sel,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] bank_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                            bank_q[g] <= '0;
      else if (wr_en && wr_sel == SW'(g))    bank_q[g] <= wr_data;
    end
  end

  // same-cycle write is forwarded to the reader
  always_comb begin
    if (wr_en && wr_sel == rd_sel) rd_data = wr_data;
    else                           rd_data = bank_q[rd_sel];
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick #(
  parameter int unsigned SW = seg_xlat_pkg::SEL_W
) (
  input  logic [SW-1:0] dflt_sel,
  input  logic          ovr_valid,
  input  logic [SW-1:0] ovr_sel,
  output logic [SW-1:0] eff_sel
);
  assign eff_sel = ovr_valid ? ovr_sel : dflt_sel;
endmodule

// File: rtl/lin_addr_gen.sv
module lin_addr_gen #(
  parameter int unsigned SEG_W   = seg_xlat_pkg::SEG_W,
  parameter int unsigned OFF_W   = seg_xlat_pkg::OFF_W,
  parameter int unsigned PARA_SH = seg_xlat_pkg::PARA_SH,
  localparam int unsigned LIN_W  = SEG_W + PARA_SH + 1
) (
  input  logic [SEG_W-1:0] seg_val,
  input  logic [OFF_W-1:0] offset,
  input  logic             gate_open,
  output logic [LIN_W-1:0] lin_addr
);
  logic [LIN_W-1:0] base, full_sum;

  assign base     = LIN_W'(seg_val) << PARA_SH;
  assign full_sum = base + LIN_W'(offset);
  assign lin_addr = gate_open ? full_sum : {1'b0, full_sum[LIN_W-2:0]};
endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
  import seg_xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [SEL_W-1:0] seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             a20_enable,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEL_W-1:0] req_seg_sel,
  input  logic             req_ovr_valid,
  input  logic [SEL_W-1:0] req_ovr_sel,
  input  logic [OFF_W-1:0] req_offset,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [LIN_W-1:0] rsp_addr
);
  localparam logic [LIN_W-1:0] MAX_LIN =
    (LIN_W'({SEG_W{1'b1}}) << PARA_SH) + LIN_W'({OFF_W{1'b1}});

  logic [SEL_W-1:0] eff_sel;
  logic [SEG_W-1:0] seg_val;
  logic [LIN_W-1:0] lin_next;
  logic             accept;

  seg_pick #(.SW(SEL_W)) u_pick (
    .dflt_sel (req_seg_sel),
    .ovr_valid(req_ovr_valid),
    .ovr_sel  (req_ovr_sel),
    .eff_sel  (eff_sel)
  );

  seg_bank #(.NUM(NUM_SEG), .WIDTH(SEG_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (seg_wr_en),
    .wr_sel (seg_wr_sel),
    .wr_data(seg_wr_data),
    .rd_sel (eff_sel),
    .rd_data(seg_val)
  );

  lin_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PARA_SH(PARA_SH)) u_gen (
    .seg_val  (seg_val),
    .offset   (req_offset),
    .gate_open(a20_enable),
    .lin_addr (lin_next)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= lin_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr));

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  assert_one_cycle_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_wrap_clears_bit20_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !a20_enable |=> !rsp_addr[LIN_W-1]);

  assert_addr_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr <= MAX_LIN);
endmodule

// File: tb/test_seg_xlat_top.sv
module test_seg_xlat_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        a20_enable = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_seg_sel = '0;
  logic        req_ovr_valid = 1'b0;
  logic [1:0]  req_ovr_sel = '0;
  logic [15:0] req_offset = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [20:0] rsp_addr;

  int errors = 0;
  int checks = 0;
  bit bp_on = 0;
  bit done = 0;
  logic [15:0] model_seg [4];
  logic [20:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  seg_xlat_top i_seg_xlat_top (.*);

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  // driver: write and/or request, held until accepted
  task automatic xlat(input bit wen, input logic [1:0] wsel, input logic [15:0] wdata,
                      input logic [1:0] dsel, input bit ov, input logic [1:0] osel,
                      input logic [15:0] off, input bit gate, input string tag,
                      input bit chk_lat = 0);
    logic [1:0]  eff;
    logic [15:0] s;
    logic [20:0] e;
    bit acc;
    @(negedge clk);
    seg_wr_en = wen; seg_wr_sel = wsel; seg_wr_data = wdata;
    req_valid = 1; req_seg_sel = dsel; req_ovr_valid = ov; req_ovr_sel = osel;
    req_offset = off; a20_enable = gate;
    eff = ov ? osel : dsel;
    s = (wen && wsel == eff) ? wdata : model_seg[eff];
    e = (21'(s) << 4) + 21'(off);
    if (!gate) e[20] = 1'b0;
    acc = 0;
    while (!acc) begin
      #1 acc = req_ready;
      @(posedge clk);
      if (acc) begin
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (wen) model_seg[wsel] = wdata;
      end else @(negedge clk);
    end
    @(negedge clk);
    seg_wr_en = 0; req_valid = 0;
    if (chk_lat) begin
      #1 check("R6 latency", 21'(rsp_valid), 21'd1);
    end
  endtask

  task automatic wr_only(input logic [1:0] wsel, input logic [15:0] wdata);
    @(negedge clk);
    seg_wr_en = 1; seg_wr_sel = wsel; seg_wr_data = wdata;
    @(posedge clk);
    model_seg[wsel] = wdata;
    @(negedge clk);
    seg_wr_en = 0;
  endtask

  // back-pressure source
  always @(negedge clk) rsp_ready <= bp_on ? 1'($urandom_range(0, 1)) : 1'b1;

  // monitor
  bit          held = 0;
  logic [20:0] held_addr;
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (held) begin
        check("R8 hold valid", 21'(rsp_valid), 21'd1);
        check("R8 hold addr", rsp_addr, held_addr);
      end
      check("R8 ready rule", 21'(req_ready), 21'(!rsp_valid || rsp_ready));
      held = rsp_valid && !rsp_ready;
      held_addr = rsp_addr;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check("R6 unexpected response", rsp_addr, 21'h1FFFFF);
        else check(tag_q.pop_front(), rsp_addr, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model_seg[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 rsp_valid reset", 21'(rsp_valid), 21'd0);
    check("R1 req_ready reset", 21'(req_ready), 21'd1);
    for (int i = 0; i < 4; i++) xlat(0, 0, 0, 2'(i), 0, 0, 16'h0000, 1, "R1 reset regs");

    // R4 loads and aliasing
    wr_only(0, 16'h06EF); wr_only(1, 16'h0812); wr_only(2, 16'h0000); wr_only(3, 16'hFFFF);
    xlat(0, 0, 0, 0, 0, 0, 16'h1234, 1, "R2 06EF:1234", 1);
    xlat(0, 0, 0, 1, 0, 0, 16'h0004, 0, "R4 alias 0812:0004");
    xlat(0, 0, 0, 2, 0, 0, 16'h8124, 0, "R4 alias 0000:8124");
    // R5 override, R3 wrap
    xlat(0, 0, 0, 0, 1, 3, 16'h0010, 0, "R3 FFFF:0010 wrap");
    xlat(0, 0, 0, 0, 1, 3, 16'h0010, 1, "R2 FFFF:0010 gate open");
    xlat(0, 0, 0, 1, 0, 3, 16'h0004, 1, "R5 override ignored when invalid");
    xlat(0, 0, 0, 3, 1, 0, 16'h1234, 1, "R5 override wins");
    // R9 ceiling
    xlat(0, 0, 0, 3, 0, 0, 16'hFFFF, 1, "R9 max 10FFEF");
    xlat(0, 0, 0, 3, 0, 0, 16'hFFFF, 0, "R9 gate closed 0FFEF");
    // FFF0 corner
    wr_only(3, 16'hFFF0);
    xlat(0, 0, 0, 3, 0, 0, 16'h0100, 0, "R3 FFF0:0100 wrap");
    xlat(0, 0, 0, 3, 0, 0, 16'h0100, 1, "R2 FFF0:0100 open");
    // R7 bypass
    xlat(1, 1, 16'h1234, 1, 0, 0, 16'h0000, 1, "R7 write-through");
    xlat(1, 2, 16'hABCD, 0, 1, 2, 16'h0005, 0, "R7 write-through override");
    xlat(1, 0, 16'h5555, 1, 0, 0, 16'h0000, 1, "R7 other reg unaffected");

    // random with back-pressure
    bp_on = 1;
    for (int n = 0; n < 300; n++)
      xlat(1'($urandom_range(0, 3) == 0), 2'($urandom), 16'($urandom), 2'($urandom),
           1'($urandom), 2'($urandom), 16'($urandom), 1'($urandom), "R2/R3 random");
    bp_on = 0;
    repeat (20) @(posedge clk);
    check("R6 queue drained", 21'(exp_q.size()), 21'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule